// File: doc/BRIEF.md
# Hardware Mutex Register Bank

A bank of hardware mutexes that lets several bus masters take turns owning shared resources. The block sits behind an external front end that has already arbitrated between ports. It sees at most one single-word access per cycle. Each access carries the number of the requesting port and a bus transaction ID.

Each mutex holds a lock flag, an 8-bit owner CPU identifier and a hidden hardware owner identifier. It also has a 32-bit user word, which is optional. Software acquires a mutex by writing its identifier with the lock bit set. It then reads the control word back to see whether it won. It releases the mutex by writing the same identifier with the lock bit clear. Writes that break the acquire or release rules are dropped without effect. When hardware protection is enabled, the hidden identifier is formed from the port number and the transaction ID. A release must then match it as well, so one master cannot free a mutex that another master holds by copying its CPU identifier.

Every access returns a response exactly one cycle later. Effects of a write are visible to a read issued in the following cycle.

Top module: `mtx_bank`

## Requirements
- R1: After reset, and after any later reset, every mutex is free and its control word reads as zero.
- R2: Address bits [12:8] select the mutex index. Byte offset 0x00 within the 256-byte window is the control word and byte offset 0x04 is the user word. Each request produces rsp_valid_o in the next cycle, with rsp_resp_o = 2'b00 (OKAY) or 2'b11 (DECERR).
- R3: A control word read returns {23'b0, owner[7:0], lock} with the lock in bit 0. Written bits 31:9 are never stored. The hidden identifier never appears in read data.
- R4: A control write with bit 0 set to a free mutex locks it and stores wdata[8:1] as the owner.
- R5: A control write with bit 0 set to a locked mutex changes nothing, even when it comes from the current owner.
- R6: A control write with bit 0 clear frees a locked mutex, clearing the whole word, only if wdata[8:1] equals the stored owner. Otherwise it is ignored.
- R7: With HW_PROT_EN=1, a release also needs {port, transaction ID} to equal the value captured at acquire. With HW_PROT_EN=0, the CPU identifier alone decides.
- R8: A release written to a free mutex has no effect and returns OKAY.
- R9: With USER_EN=1, the user word stores all 32 written bits and reads them back; it resets to zero. With USER_EN=0, it reads zero and writes to it are ignored.
- R10: Any other byte offset within a window reads zero, and writes to it change no state.
- R11: A mutex index at or above NUM_MUTEX returns DECERR with zero read data, and the access changes no state.
- R12: A write to an in-range mutex returns OKAY with zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Byte address (index in [12:8], offset in [7:0]) |
| req_wdata_i | input | 32 | Write data |
| req_port_i | input | PORT_W | Number of the requesting port |
| req_txn_i | input | TXN_W | Bus transaction ID of the access |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data (zero for writes) |
| rsp_resp_o | output | 2 | 2'b00 OKAY, 2'b11 DECERR |

## Verification
The main instance is built with six mutexes and with both the user word and hardware protection enabled. This leaves indices 6 to 31 free to probe the decode-error path. It also means releases can be tried with a correct CPU identifier but the wrong port or the wrong transaction ID.

A second instance has two mutexes and neither option. It shows that a release from a different port succeeds when protection is off, and that the user word then reads as zero.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int DATA_W      = 32;
  localparam int CPUID_W     = 8;
  localparam int IDX_FIELD_W = 5;
  localparam int WIN_LSB     = 8;
  localparam int ADDR_W      = WIN_LSB + IDX_FIELD_W;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_DECERR = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_USER = 2'd1,
    OFS_RSVD = 2'd2
  } ofs_e;

  typedef struct packed {
    logic                   hit;
    logic [IDX_FIELD_W-1:0] idx;
    ofs_e                   ofs;
  } dec_t;
endpackage

// File: rtl/mtx_decode.sv
module mtx_decode
  import mtx_pkg::*;
#(
  parameter int NUM_MUTEX = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic [IDX_FIELD_W-1:0] idx;
  logic [WIN_LSB-1:0]     ofs;

  assign idx = addr_i[ADDR_W-1:WIN_LSB];
  assign ofs = addr_i[WIN_LSB-1:0];

  always_comb begin
    dec_o.idx = idx;
    dec_o.hit = ({1'b0, idx} < (IDX_FIELD_W+1)'(NUM_MUTEX));
    if (ofs == 8'h00)      dec_o.ofs = OFS_CTRL;
    else if (ofs == 8'h04) dec_o.ofs = OFS_USER;
    else                   dec_o.ofs = OFS_RSVD;
  end
endmodule

// File: rtl/mtx_cell.sv
module mtx_cell
  import mtx_pkg::*;
#(
  parameter bit USER_EN    = 1'b1,
  parameter bit HW_PROT_EN = 1'b1,
  parameter int HWID_W     = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               user_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [HWID_W-1:0]  hwid_i,
  output logic               lock_o,
  output logic [CPUID_W-1:0] owner_o,
  output logic [DATA_W-1:0]  user_o
);
  logic               lock_q;
  logic [CPUID_W-1:0] owner_q;
  logic [CPUID_W-1:0] cpuid_w;
  logic               hw_ok;
  logic               do_acq, do_rel;

  assign cpuid_w = wdata_i[CPUID_W:1];
  assign do_acq  = ctrl_we_i &  wdata_i[0] & ~lock_q;
  assign do_rel  = ctrl_we_i & ~wdata_i[0] &  lock_q & (cpuid_w == owner_q) & hw_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
    end else if (do_acq) begin
      lock_q  <= 1'b1;
      owner_q <= cpuid_w;
    end else if (do_rel) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
    end
  end

  // Hidden owner tag: never leaves this module
  if (HW_PROT_EN) begin : g_prot
    logic [HWID_W-1:0] hwid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hwid_q <= '0;
      else if (do_acq) hwid_q <= hwid_i;
      else if (do_rel) hwid_q <= '0;
    end
    assign hw_ok = (hwid_q == hwid_i);
  end else begin : g_noprot
    assign hw_ok = 1'b1;
  end

  if (USER_EN) begin : g_user
    logic [DATA_W-1:0] user_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        user_q <= '0;
      else if (user_we_i) user_q <= wdata_i;
    end
    assign user_o = user_q;
  end else begin : g_nouser
    assign user_o = '0;
  end

  assign lock_o  = lock_q;
  assign owner_o = owner_q;

  // R4
  acquire_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[0] && !lock_q) |=> (lock_q && owner_q == $past(wdata_i[CPUID_W:1])));
  // R5
  acquire_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[0] && lock_q) |=> (lock_q && $stable(owner_q)));
  // R6
  release_mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wdata_i[0] && lock_q && wdata_i[CPUID_W:1] != owner_q) |=> lock_q);
  // R6
  release_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(ctrl_we_i && !wdata_i[0] && wdata_i[CPUID_W:1] == owner_q));
  // R3
  owner_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> (owner_q == '0));
endmodule

// File: rtl/mtx_rdmux.sv
module mtx_rdmux
  import mtx_pkg::*;
#(
  parameter int NUM_MUTEX = 16
) (
  input  dec_t               dec_i,
  input  logic               lock_i  [NUM_MUTEX],
  input  logic [CPUID_W-1:0] owner_i [NUM_MUTEX],
  input  logic [DATA_W-1:0]  user_i  [NUM_MUTEX],
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int PAD_W = DATA_W - CPUID_W - 1;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_MUTEX; i++) begin
      if (dec_i.hit && dec_i.idx == IDX_FIELD_W'(i)) begin
        case (dec_i.ofs)
          OFS_CTRL: rdata_o = {{PAD_W{1'b0}}, owner_i[i], lock_i[i]};
          OFS_USER: rdata_o = user_i[i];
          default:  rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mtx_bank.sv
module mtx_bank
  import mtx_pkg::*;
#(
  parameter int NUM_MUTEX  = 16,
  parameter bit USER_EN    = 1'b1,
  parameter bit HW_PROT_EN = 1'b1,
  parameter int PORT_W     = 3,
  parameter int TXN_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [12:0]       req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [TXN_W-1:0]  req_txn_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic [1:0]        rsp_resp_o
);
  localparam int HWID_W = PORT_W + TXN_W;

  dec_t               dec;
  logic [HWID_W-1:0]  hwid;
  logic               lock  [NUM_MUTEX];
  logic [CPUID_W-1:0] owner [NUM_MUTEX];
  logic [DATA_W-1:0]  user  [NUM_MUTEX];
  logic [DATA_W-1:0]  rd_mux;
  logic               wr_hit;

  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  rsp_e              rsp_resp_q;

  assign hwid   = {req_port_i, req_txn_i};
  assign wr_hit = req_valid_i & req_write_i & dec.hit;

  mtx_decode #(.NUM_MUTEX(NUM_MUTEX)) u_dec (
    .addr_i (req_addr_i),
    .dec_o  (dec)
  );

  for (genvar g = 0; g < NUM_MUTEX; g++) begin : g_cell
    logic sel;
    assign sel = wr_hit && (dec.idx == IDX_FIELD_W'(g));
    mtx_cell #(
      .USER_EN   (USER_EN),
      .HW_PROT_EN(HW_PROT_EN),
      .HWID_W    (HWID_W)
    ) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (sel && dec.ofs == OFS_CTRL),
      .user_we_i (sel && dec.ofs == OFS_USER),
      .wdata_i   (req_wdata_i),
      .hwid_i    (hwid),
      .lock_o    (lock[g]),
      .owner_o   (owner[g]),
      .user_o    (user[g])
    );
  end

  mtx_rdmux #(.NUM_MUTEX(NUM_MUTEX)) u_rdmux (
    .dec_i   (dec),
    .lock_i  (lock),
    .owner_i (owner),
    .user_i  (user),
    .rdata_o (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_resp_q  <= RSP_OKAY;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_rdata_q <= (req_valid_i && !req_write_i) ? rd_mux : '0;
      rsp_resp_q  <= dec.hit ? RSP_OKAY : RSP_DECERR;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_resp_o  = rsp_resp_q;

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R11
  out_of_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !dec.hit) |=> (rsp_resp_o == 2'b11 && rsp_rdata_o == '0));
  // R12
  write_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && dec.hit) |=> (rsp_resp_o == 2'b00 && rsp_rdata_o == '0));
endmodule

// File: tb/mtx_bank_tb.sv
module mtx_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, wr = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wd = '0;
  logic [2:0]  port = '0;
  logic [3:0]  txn = '0;

  logic        a_vld, b_vld;
  logic [31:0] a_rd, b_rd;
  logic [1:0]  a_rs, b_rs;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mtx_bank #(.NUM_MUTEX(6), .USER_EN(1'b1), .HW_PROT_EN(1'b1), .PORT_W(3), .TXN_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr), .req_addr_i(addr),
    .req_wdata_i(wd), .req_port_i(port), .req_txn_i(txn),
    .rsp_valid_o(a_vld), .rsp_rdata_o(a_rd), .rsp_resp_o(a_rs));

  mtx_bank #(.NUM_MUTEX(2), .USER_EN(1'b0), .HW_PROT_EN(1'b0), .PORT_W(3), .TXN_W(4)) dut_np_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr), .req_addr_i(addr),
    .req_wdata_i(wd), .req_port_i(port), .req_txn_i(txn),
    .rsp_valid_o(b_vld), .rsp_rdata_o(b_rd), .rsp_resp_o(b_rs));

  typedef struct packed {
    logic [7:0]  req;
    logic        w;
    logic [12:0] a;
    logic [31:0] d;
    logic [2:0]  p;
    logic [3:0]  t;
    logic [31:0] erd;
    logic [1:0]  ers;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  1'b0, 13'h0000, 32'h0,        3'd0, 4'd0,  32'h0,        2'b00}, // R1
    '{8'd1,  1'b0, 13'h0500, 32'h0,        3'd0, 4'd0,  32'h0,        2'b00}, // R1
    '{8'd4,  1'b1, 13'h0000, 32'h25,       3'd1, 4'd3,  32'h0,        2'b00}, // R4 R12
    '{8'd3,  1'b0, 13'h0000, 32'h0,        3'd0, 4'd0,  32'h25,       2'b00}, // R3
    '{8'd5,  1'b1, 13'h0000, 32'h0B,       3'd2, 4'd0,  32'h0,        2'b00}, // R5
    '{8'd5,  1'b0, 13'h0000, 32'h0,        3'd0, 4'd0,  32'h25,       2'b00}, // R5
    '{8'd6,  1'b1, 13'h0000, 32'h0A,       3'd1, 4'd3,  32'h0,        2'b00}, // R6 wrong cpuid
    '{8'd6,  1'b0, 13'h0000, 32'h0,        3'd0, 4'd0,  32'h25,       2'b00}, // R6
    '{8'd7,  1'b1, 13'h0000, 32'h24,       3'd2, 4'd3,  32'h0,        2'b00}, // R7 wrong port
    '{8'd7,  1'b0, 13'h0000, 32'h0,        3'd0, 4'd0,  32'h25,       2'b00}, // R7
    '{8'd7,  1'b1, 13'h0000, 32'h24,       3'd1, 4'd4,  32'h0,        2'b00}, // R7 wrong txn
    '{8'd7,  1'b0, 13'h0000, 32'h0,        3'd0, 4'd0,  32'h25,       2'b00}, // R7
    '{8'd6,  1'b1, 13'h0000, 32'h24,       3'd1, 4'd3,  32'h0,        2'b00}, // R6 good release
    '{8'd6,  1'b0, 13'h0000, 32'h0,        3'd0, 4'd0,  32'h0,        2'b00}, // R6
    '{8'd8,  1'b1, 13'h0000, 32'h24,       3'd1, 4'd3,  32'h0,        2'b00}, // R8
    '{8'd8,  1'b0, 13'h0000, 32'h0,        3'd0, 4'd0,  32'h0,        2'b00}, // R8
    '{8'd9,  1'b1, 13'h0304, 32'hDEADBEEF, 3'd0, 4'd0,  32'h0,        2'b00}, // R9
    '{8'd9,  1'b0, 13'h0304, 32'h0,        3'd0, 4'd0,  32'hDEADBEEF, 2'b00}, // R9
    '{8'd10, 1'b1, 13'h0308, 32'hFFFFFFFF, 3'd0, 4'd0,  32'h0,        2'b00}, // R10
    '{8'd10, 1'b0, 13'h0308, 32'h0,        3'd0, 4'd0,  32'h0,        2'b00}, // R10
    '{8'd11, 1'b1, 13'h0600, 32'h03,       3'd0, 4'd0,  32'h0,        2'b11}, // R11
    '{8'd11, 1'b0, 13'h0600, 32'h0,        3'd0, 4'd0,  32'h0,        2'b11}, // R11
    '{8'd11, 1'b0, 13'h1F04, 32'h0,        3'd0, 4'd0,  32'h0,        2'b11}, // R11
    '{8'd4,  1'b1, 13'h0500, 32'h1FF,      3'd7, 4'd15, 32'h0,        2'b00}, // R4
    '{8'd4,  1'b0, 13'h0500, 32'h0,        3'd0, 4'd0,  32'h1FF,      2'b00}, // R4
    '{8'd3,  1'b1, 13'h0200, 32'hFFFFFE03, 3'd0, 4'd0,  32'h0,        2'b00}, // R3
    '{8'd3,  1'b0, 13'h0200, 32'h0,        3'd0, 4'd0,  32'h3,        2'b00}, // R3
    '{8'd9,  1'b0, 13'h0004, 32'h0,        3'd0, 4'd0,  32'h0,        2'b00}  // R9 reset value
  };

  task automatic acc(input logic w, input logic [12:0] a, input logic [31:0] d,
                     input logic [2:0] p, input logic [3:0] t);
    @(negedge clk);
    vld = 1'b1; wr = w; addr = a; wd = d; port = p; txn = t;
    @(negedge clk);
    vld = 1'b0; wr = 1'b0; wd = '0;
  endtask

  task automatic chk(input string tag, input logic v, input logic [31:0] rd, input logic [1:0] rs,
                     input logic [31:0] erd, input logic [1:0] ers);
    checks++;
    if (v !== 1'b1 || rd !== erd || rs !== ers) begin
      fails++;
      $display("FAIL %s: got valid=%b rdata=%h resp=%b, expected valid=1 rdata=%h resp=%b",
               tag, v, rd, rs, erd, ers);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].w, VECS[i].a, VECS[i].d, VECS[i].p, VECS[i].t);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), a_vld, a_rd, a_rs, VECS[i].erd, VECS[i].ers);
    end

    // R1: reset while mutex 5 is held
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    acc(1'b0, 13'h0500, 32'h0, 3'd0, 4'd0);
    chk("R1 re-reset", a_vld, a_rd, a_rs, 32'h0, 2'b00);

    // Unprotected, no-user instance
    acc(1'b1, 13'h0100, 32'h25, 3'd1, 4'd3);
    chk("R12 np write", b_vld, b_rd, b_rs, 32'h0, 2'b00);
    acc(1'b0, 13'h0100, 32'h0, 3'd0, 4'd0);
    chk("R4 np acquire", b_vld, b_rd, b_rs, 32'h25, 2'b00);
    acc(1'b1, 13'h0100, 32'h24, 3'd2, 4'd0);
    acc(1'b0, 13'h0100, 32'h0, 3'd0, 4'd0);
    chk("R7 np release other port", b_vld, b_rd, b_rs, 32'h0, 2'b00);
    acc(1'b1, 13'h0004, 32'h5A5A, 3'd0, 4'd0);
    acc(1'b0, 13'h0004, 32'h0, 3'd0, 4'd0);
    chk("R9 np user off", b_vld, b_rd, b_rs, 32'h0, 2'b00);
    acc(1'b0, 13'h0200, 32'h0, 3'd0, 4'd0);
    chk("R11 np range", b_vld, b_rd, b_rs, 32'h0, 2'b11);
    // R2: protected instance saw the user write to mutex 0
    acc(1'b0, 13'h0004, 32'h0, 3'd0, 4'd0);
    chk("R2 user offset", a_vld, a_rd, a_rs, 32'h5A5A, 2'b00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule